// File: doc/BRIEF.md
# Hold-Scan Register with In-Place Exchange

This block is a parameterised chain of hold-scan cells for scan-based delay testing. Each cell holds a system flop, which drives the logic under test, and a shadow master-slave pair (an A latch feeding a B latch), which forms the serial scan path. Because the two are separate, a new test vector can be shifted into the shadow chain while the vector already applied to the logic under test stays exactly where it is. That property is what makes two-vector transition tests possible.

A 3-bit command input selects one operation per cycle:
- shift the scan path by one bit;
- copy shadow to system (store);
- copy system to shadow (load);
- capture the response of the logic under test into the system register;
- exchange the two registers.

Exchange swaps the shadow and system contents without losing either value. It uses three ordered latch transfers and needs no spare storage in the cell.

Exchange lets a test flow reuse the vector waiting in the shadow chain as the initial vector of the next pattern. At the same time it moves the captured response into the shadow chain so that it can be shifted out. While the exchange runs, a busy flag is high and every other command is ignored. A one-cycle done pulse marks the end of the exchange.

Top module: `hsx_chain`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `sys_out`, `scan_out`, `busy` and `done` are all 0, and the shadow chain holds all zeros.
- R2: Command code 1 (shift) moves the shadow chain one place per cycle. `scan_in` enters shadow bit 0, each shadow bit i takes the old value of bit i-1, and `scan_out` always shows shadow bit WIDTH-1.
- R3: A shift never changes `sys_out`.
- R4: Command code 2 (store) copies every shadow bit into the matching system bit in one cycle.
- R5: Command code 3 (load) copies every system bit into the matching shadow bit in one cycle, overwriting the shadow chain. The system register is unchanged.
- R6: Command code 4 (capture) writes `func_in` into the system register in one cycle. The shadow chain is unchanged.
- R7: Command code 5 (exchange) leaves the old shadow value in the system register and the old system value in the shadow chain. Two exchanges in a row restore both registers.
- R8: An exchange accepted at clock edge E0 runs one latch transfer at each of E1, E2 and E3:
  - E1: system to A latch.
  - E2: B latch to system. `sys_out` changes at E2.
  - E3: A latch to B latch.

  `busy` is high for exactly the three cycles after E0. `done` is high for exactly the one cycle after E3.
- R9: Any command presented while `busy` is high, including another exchange, has no effect on either register.
- R10: Code 0 (idle) and the unused codes 6 and 7 change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code: 0 idle, 1 shift, 2 store, 3 load, 4 capture, 5 exchange, 6 and 7 unused |
| scan_in | input | 1 | Serial scan input into shadow bit 0 |
| func_in | input | WIDTH | Response of the logic under test, written by capture |
| sys_out | output | WIDTH | System register, drives the logic under test |
| scan_out | output | 1 | Serial scan output, shadow bit WIDTH-1 |
| busy | output | 1 | High while an exchange is in progress |
| done | output | 1 | One-cycle pulse after an exchange finishes |

## Verification
The bench checks five corner cases of this block:
- **Shift disturbing the system register.** A design that lets shifting reach the system register would corrupt the applied vector, so `sys_out` is checked at every shift cycle.
- **Exchange losing a value.** An exchange done in the wrong step order would duplicate one register into the other. The bench therefore reads both registers back after one exchange and again after a second exchange, which must restore the originals.
- **Exchange timing.** Off-by-one sequencing would show up as `busy` lasting two or four cycles, or as `sys_out` changing at the wrong edge, so both are checked cycle by cycle.
- **Commands during an exchange.** A design that lets capture, store or a second exchange through while busy would finish with the wrong contents.
- **Unused codes.** A design that decodes the unused codes as commands would disturb the registers.

// File: rtl/hsx_pkg.sv
`timescale 1ns/1ps
package hsx_pkg;

    // Command codes on the cmd port; 6 and 7 are unused.
    localparam logic [2:0] C_IDLE    = 3'd0;
    localparam logic [2:0] C_SHIFT   = 3'd1;
    localparam logic [2:0] C_STORE   = 3'd2;
    localparam logic [2:0] C_LOAD    = 3'd3;
    localparam logic [2:0] C_CAPTURE = 3'd4;
    localparam logic [2:0] C_EXCH    = 3'd5;

    // Exchange sequencer states
    typedef enum logic [1:0] {
        X_IDLE = 2'd0,
        X_S1   = 2'd1,   // system -> A latch
        X_S2   = 2'd2,   // B latch -> system
        X_S3   = 2'd3    // A latch -> B latch
    } hsx_xstate_e;

    // Per-cycle transfer enables broadcast to every cell
    typedef struct packed {
        logic shift;
        logic store;
        logic load;
        logic capture;
        logic xa;   // system -> A latch
        logic xs;   // B latch -> system
        logic xb;   // A latch -> B latch
    } hsx_ctl_t;

    function automatic hsx_xstate_e hsx_next_step(input hsx_xstate_e s);
        case (s)
            X_S1:    return X_S2;
            X_S2:    return X_S3;
            default: return X_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/hsx_cell.sv
`timescale 1ns/1ps
module hsx_cell
    import hsx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  hsx_ctl_t ctl,
    input  logic     si,
    input  logic     fin,
    output logic     sys_q,
    output logic     b_q
);

    logic a_q;

    // Shadow master-slave pair: a shift is phase A then phase B in one clock.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else if (ctl.shift) begin
            a_q <= si;
            b_q <= si;
        end else if (ctl.load) begin
            a_q <= sys_q;
            b_q <= sys_q;
        end else if (ctl.xa) begin
            a_q <= sys_q;
        end else if (ctl.xb) begin
            b_q <= a_q;
        end
    end

    // System flop: written only by store, capture or the exchange's middle step.
    always_ff @(posedge clk) begin
        if (rst) begin
            sys_q <= 1'b0;
        end else if (ctl.store || ctl.xs) begin
            sys_q <= b_q;
        end else if (ctl.capture) begin
            sys_q <= fin;
        end
    end

endmodule

// File: rtl/hsx_ctrl.sv
`timescale 1ns/1ps
module hsx_ctrl
    import hsx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cmd,
    output hsx_ctl_t   ctl,
    output logic       busy,
    output logic       done
);

    hsx_xstate_e state_q, state_d;

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        case (state_q)
            X_S1: begin ctl.xa = 1'b1; state_d = hsx_next_step(state_q); end
            X_S2: begin ctl.xs = 1'b1; state_d = hsx_next_step(state_q); end
            X_S3: begin ctl.xb = 1'b1; state_d = hsx_next_step(state_q); end
            default: begin
                case (cmd)
                    C_SHIFT:   ctl.shift   = 1'b1;
                    C_STORE:   ctl.store   = 1'b1;
                    C_LOAD:    ctl.load    = 1'b1;
                    C_CAPTURE: ctl.capture = 1'b1;
                    C_EXCH:    state_d     = X_S1;
                    default:   ;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= X_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= (state_q == X_S3);
        end
    end

    assign busy = (state_q != X_IDLE);

endmodule

// File: rtl/hsx_chain.sv
`timescale 1ns/1ps
module hsx_chain
    import hsx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cmd,
    input  logic             scan_in,
    input  logic [WIDTH-1:0] func_in,
    output logic [WIDTH-1:0] sys_out,
    output logic             scan_out,
    output logic             busy,
    output logic             done
);

    localparam int LAST = WIDTH - 1;

    hsx_ctl_t         ctl;
    logic [WIDTH-1:0] sh_b;
    logic [WIDTH-1:0] ser_in;

    hsx_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .ctl  (ctl),
        .busy (busy),
        .done (done)
    );

    assign ser_in[0] = scan_in;

    genvar i;
    generate
        for (i = 1; i < WIDTH; i++) begin : g_link
            assign ser_in[i] = sh_b[i-1];
        end
        for (i = 0; i < WIDTH; i++) begin : g_cell
            hsx_cell u_cell (
                .clk   (clk),
                .rst   (rst),
                .ctl   (ctl),
                .si    (ser_in[i]),
                .fin   (func_in[i]),
                .sys_q (sys_out[i]),
                .b_q   (sh_b[i])
            );
        end
    endgenerate

    assign scan_out = sh_b[LAST];

endmodule

// File: rtl/hsx_chain_chk.sv
`timescale 1ns/1ps
module hsx_chain_chk
    import hsx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cmd,
    input logic             scan_in,
    input logic [WIDTH-1:0] func_in,
    input logic [WIDTH-1:0] sys_out,
    input logic [WIDTH-1:0] shadow,
    input logic             busy,
    input logic             done
);

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd == C_SHIFT) |=> shadow[0] == $past(scan_in)); // R2

    AST_SHIFT_KEEPS_SYS: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd == C_SHIFT) |=> $stable(sys_out)); // R3

    AST_STORE_COPY: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd == C_STORE) |=> sys_out == $past(shadow)); // R4

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd == C_LOAD) |=> shadow == $past(sys_out) && $stable(sys_out)); // R5

    AST_CAPTURE_TAKE: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd == C_CAPTURE) |=> sys_out == $past(func_in) && $stable(shadow)); // R6

    AST_EXCH_BUSY_RUN: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd == C_EXCH) |=> busy ##1 busy ##1 busy ##1 (!busy && done)); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (!busy && (cmd == C_IDLE || cmd == 3'd6 || cmd == 3'd7))
            |=> $stable(sys_out) && $stable(shadow)); // R10

endmodule

bind hsx_chain hsx_chain_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .scan_in (scan_in),
    .func_in (func_in),
    .sys_out (sys_out),
    .shadow  (sh_b),
    .busy    (busy),
    .done    (done)
);

// File: tb/sim_hsx_chain.sv
`timescale 1ns/1ps
module sim_hsx_chain;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   cmd = 3'd0;
    logic         scan_in = 1'b0;
    logic [W-1:0] func_in = '0;
    logic [W-1:0] sys_out;
    logic         scan_out;
    logic         busy;
    logic         done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hsx_chain #(.WIDTH(W)) u0 (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .scan_in  (scan_in),
        .func_in  (func_in),
        .sys_out  (sys_out),
        .scan_out (scan_out),
        .busy     (busy),
        .done     (done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, result visible at the next negedge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_cmd(input logic [2:0] c);
        cmd = c;
        tick();
        cmd = 3'd0;
    endtask

    // Shift W bits MSB first; collect the old shadow contents.
    task automatic scan_word(input logic [W-1:0] din, output logic [W-1:0] dout);
        logic [W-1:0] sys_before;
        bit moved;
        sys_before = sys_out;
        moved = 0;
        for (int k = 0; k < W; k++) begin
            dout[W-1-k] = scan_out;
            scan_in = din[W-1-k];
            cmd = 3'd1;
            tick();
            if (sys_out !== sys_before) moved = 1;
        end
        cmd = 3'd0;
        chk("R3 sys_out stable across shifts", {31'd0, moved}, 32'd0);
    endtask

    task automatic t_reset();
        logic [W-1:0] o;
        rst = 1'b1;
        repeat (3) tick();
        chk("R1 sys_out in reset", sys_out, 0);
        chk("R1 busy in reset", busy, 0);
        rst = 1'b0;
        tick();
        chk("R1 done after reset", done, 0);
        chk("R1 scan_out after reset", scan_out, 0);
        scan_word(8'h00, o);
        chk("R1 shadow zero after reset", o, 0);
    endtask

    task automatic t_shift_store();
        logic [W-1:0] o;
        scan_word(8'hB6, o);
        chk("R2 scan_out MSB after shift-in", scan_out, 1);
        scan_word(8'h5D, o);
        chk("R2 shifted-out word", o, 8'hB6);
        do_cmd(3'd2);
        chk("R4 store copies shadow", sys_out, 8'h5D);
        scan_word(8'h21, o);
        chk("R4 shadow unchanged by store", o, 8'h5D);
        chk("R3 sys_out kept after shifting", sys_out, 8'h5D);
    endtask

    task automatic t_capture_load();
        logic [W-1:0] o;
        func_in = 8'hC3;
        do_cmd(3'd4);
        chk("R6 capture takes func_in", sys_out, 8'hC3);
        scan_word(8'h00, o);
        chk("R6 shadow unchanged by capture", o, 8'h21);
        do_cmd(3'd3);
        chk("R5 load keeps sys_out", sys_out, 8'hC3);
        scan_word(8'h00, o);
        chk("R5 load copies sys into shadow", o, 8'hC3);
    endtask

    task automatic t_exchange();
        logic [W-1:0] o;
        logic [W-1:0] t;
        scan_word(8'hA5, o);
        func_in = 8'h3C;
        do_cmd(3'd4);
        cmd = 3'd5;
        tick();                       // after E0
        cmd = 3'd0;
        chk("R8 busy after E0", busy, 1);
        chk("R8 sys_out held after E0", sys_out, 8'h3C);
        tick();                       // after E1
        chk("R8 busy after E1", busy, 1);
        chk("R8 sys_out held after E1", sys_out, 8'h3C);
        tick();                       // after E2
        chk("R8 busy after E2", busy, 1);
        chk("R8 sys_out changes at E2", sys_out, 8'hA5);
        chk("R8 done low during run", done, 0);
        tick();                       // after E3
        chk("R8 busy low after E3", busy, 0);
        chk("R8 done after E3", done, 1);
        tick();
        chk("R8 done single pulse", done, 0);
        chk("R7 sys holds old shadow", sys_out, 8'hA5);
        // Second exchange restores; then read shadow.
        do_cmd(3'd5);
        repeat (3) tick();
        chk("R7 second exchange restores sys", sys_out, 8'h3C);
        scan_word(8'h00, t);
        chk("R7 second exchange restores shadow", t, 8'hA5);
        // Read shadow after a single exchange.
        scan_word(8'h77, t);
        do_cmd(3'd5);
        repeat (3) tick();
        scan_word(8'h00, t);
        chk("R7 shadow holds old sys", t, 8'h3C);
        chk("R7 sys holds old shadow 77", sys_out, 8'h77);
    endtask

    task automatic t_ignore_busy();
        logic [W-1:0] o;
        scan_word(8'h0F, o);
        func_in = 8'hF0;
        do_cmd(3'd4);
        cmd = 3'd5;
        tick();
        func_in = 8'hFF;
        cmd = 3'd4;
        tick();
        cmd = 3'd2;
        tick();
        cmd = 3'd5;
        tick();
        cmd = 3'd0;
        chk("R9 exchange still ends on time", done, 1);
        tick();
        chk("R9 no second exchange started", busy, 0);
        chk("R9 sys ignores commands while busy", sys_out, 8'h0F);
        scan_word(8'h00, o);
        chk("R9 shadow ignores commands while busy", o, 8'hF0);
        cmd = 3'd1;                    // shift while busy must not move the chain
        scan_word(8'h99, o);
        do_cmd(3'd5);
        cmd = 3'd1;
        scan_in = 1'b0;
        repeat (3) tick();
        cmd = 3'd0;
        scan_word(8'h00, o);
        chk("R9 shift ignored while busy", o, 8'h0F);
    endtask

    task automatic t_reserved();
        logic [W-1:0] o;
        logic [W-1:0] s;
        scan_word(8'h6E, o);
        func_in = 8'h11;
        s = sys_out;
        do_cmd(3'd6);
        do_cmd(3'd7);
        do_cmd(3'd0);
        chk("R10 sys_out unchanged by codes 6,7,0", sys_out, s);
        scan_word(8'h00, o);
        chk("R10 shadow unchanged by codes 6,7,0", o, 8'h6E);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_shift_store();
        t_capture_load();
        t_exchange();
        t_ignore_busy();
        t_reserved();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule